// File: doc/BRIEF.md
# Free-Running Match Timer

This block is a memory-mapped up-counter that raises an interrupt when the count steps onto a programmable compare value. The counter runs freely and wraps from all-ones back to zero. Software schedules periodic interrupts by moving the compare value forward after each event. A prescaler divides the clock by 1, 16 or 256 before the counter sees it. The interrupt works in one of two modes. In pulse mode the status lasts a single cycle. In latched mode the status holds until software clears it.

Software drives the block through a simple single-cycle register port. A write to the load word places a new value in the counter at once. When the auto-reload option is on, loading zero also freezes the counter even with the run bit set. The counter stays frozen until a nonzero load, or until a control write that sets run. Read data is returned one cycle after the request.

Top module: `frt_match_timer`

## Requirements
- R1: After reset the count, load, compare and control words all read zero and `irq` is low.
- R2: While running, the count rises by exactly one per prescaled tick and wraps from 0xFFFFFFFF to 0 without stopping.
- R3: A write to offset 0x20 stores the load word and places the written value in the count on the next cycle, and this overrides any increment.
- R4: With control bit 6 (auto-reload) set, writing zero to 0x20 sets the count to zero and freezes it even though bit 7 (run) is set. The freeze ends on a nonzero load write, or on a control write with bit 7 set. With bit 6 clear, loading zero does not freeze the counter.
- R5: Control bits 3:2 pick the tick rate: 00 gives every cycle, 01 every 16th cycle, and 10 or 11 every 256th cycle. The prescaler restarts on every control write.
- R6: A match event fires only when the count advances onto the compare value (offset 0x30). `irq` rises in the same cycle that the count first shows that value. Loading the compare value, or sitting on it while stopped, fires nothing.
- R7: With control bit 0 clear (pulse mode), `irq` is high for exactly one cycle per match event.
- R8: With control bit 0 set (latched mode), `irq` stays high until a write of zero to offset 0x2C. A nonzero write there has no effect.
- R9: The read map is as follows. 0x20, 0x2C, 0x34, 0x38 and 0x3C return the load word. 0x24 returns the count. 0x30 returns the compare value. 0x28 returns control bits 0, 2, 3, 6 and 7, with the interrupt status in bit 8 and zeros elsewhere. Any other or misaligned offset reads zero, and writes to 0x24 are ignored.
- R10: With control bit 7 clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq | output | 1 | Interrupt status |

## Verification
The bound checker watches several rules on every cycle. It checks that the count advances by at most one, that a load write lands in the count, and that a zero load under auto-reload freezes it. It also checks that a stopped or frozen count holds, that a rising `irq` coincides with the compare value, that a pulse lasts one cycle, and that a latched status survives anything except a zero write to the clear word. Other behaviour can only be shown by the bench's scenarios, because it depends on exact cycle counts. This covers the distance to an event at each prescale setting, the wrap from all-ones to zero, the release of a freeze, and the register read map with its alias offsets.

// File: rtl/frt_pkg.sv
package frt_pkg;

  // Word indices (byte offset >> 2) of the register map
  localparam int unsigned WI_LOAD   = 8;   // 0x20
  localparam int unsigned WI_COUNT  = 9;   // 0x24
  localparam int unsigned WI_CTRL   = 10;  // 0x28
  localparam int unsigned WI_ICLR   = 11;  // 0x2C
  localparam int unsigned WI_MATCH  = 12;  // 0x30
  localparam int unsigned WI_ALIAS0 = 13;  // 0x34 .. 0x3C
  localparam int unsigned N_ALIAS   = 3;

  // Control word bit positions
  localparam int unsigned CB_LEVEL  = 0;
  localparam int unsigned CB_DIV_LO = 2;
  localparam int unsigned CB_DIV_HI = 3;
  localparam int unsigned CB_RELOAD = 6;
  localparam int unsigned CB_RUN    = 7;
  localparam int unsigned CB_STAT   = 8;

  typedef enum logic [1:0] {
    DIV_1   = 2'b00,
    DIV_16  = 2'b01,
    DIV_256 = 2'b10,
    DIV_ALT = 2'b11
  } div_sel_e;

  typedef struct packed {
    logic     run;
    logic     reload;
    div_sel_e div;
    logic     level;
  } ctrl_t;

  function automatic logic [8:0] ctrl_word(input ctrl_t c, input logic stat);
    logic [8:0] w;
    w = '0;
    w[CB_LEVEL]  = c.level;
    w[CB_DIV_LO] = c.div[0];
    w[CB_DIV_HI] = c.div[1];
    w[CB_RELOAD] = c.reload;
    w[CB_RUN]    = c.run;
    w[CB_STAT]   = stat;
    return w;
  endfunction

endpackage

// File: rtl/frt_prescale.sv
module frt_prescale #(
  parameter int unsigned MID_LOG2 = 4,
  parameter int unsigned HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       enable,
  input  logic [1:0] sel,
  output logic       tick
);
  import frt_pkg::*;

  logic [HI_LOG2-1:0] pre_q;
  logic               mid_wrap;
  logic               hi_wrap;

  always_ff @(posedge clk) begin
    if (rst || clear) pre_q <= '0;
    else if (enable)  pre_q <= pre_q + 1'b1;
  end

  generate
    if (MID_LOG2 == 0) begin : g_mid_none
      assign mid_wrap = 1'b1;
    end else begin : g_mid_tap
      assign mid_wrap = &pre_q[MID_LOG2-1:0];
    end
  endgenerate

  assign hi_wrap = &pre_q;

  always_comb begin
    unique case (div_sel_e'(sel))
      DIV_1:   tick = enable;
      DIV_16:  tick = enable && mid_wrap;
      default: tick = enable && hi_wrap;
    endcase
  end

endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             halt_set,
  input  logic             halt_clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count,
  output logic             halted,
  output logic             hit
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_inc;
  logic             halted_q;

  assign count_inc = count_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (load_we) count_q <= load_val;
    else if (tick)    count_q <= count_inc;
  end

  always_ff @(posedge clk) begin
    if (rst)           halted_q <= 1'b0;
    else if (halt_set) halted_q <= 1'b1;
    else if (halt_clr) halted_q <= 1'b0;
  end

  // Event only when the count steps onto the compare value
  assign hit    = tick && !load_we && (count_inc == match_val);
  assign count  = count_q;
  assign halted = halted_q;

endmodule

// File: rtl/frt_irq.sv
module frt_irq (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic level_mode,
  input  logic clr_zero,
  output logic status
);

  logic status_q;

  always_ff @(posedge clk) begin
    if (rst)             status_q <= 1'b0;
    else if (hit)        status_q <= 1'b1;
    else if (!level_mode) status_q <= 1'b0;
    else if (clr_zero)   status_q <= 1'b0;
  end

  assign status = status_q;

endmodule

// File: rtl/frt_match_timer.sv
module frt_match_timer #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned MID_LOG2 = 4,
  parameter int unsigned HI_LOG2  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import frt_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   widx;
  logic               aligned;
  logic               wr_en;
  logic               rd_en;
  logic               load_we;
  logic               ctrl_we;
  logic               iclr_we;
  logic               match_we;
  logic [N_ALIAS-1:0] alias_hit;
  logic               load_view;

  logic [CNT_W-1:0]   wdata_cnt;
  logic [CNT_W-1:0]   load_q;
  logic [CNT_W-1:0]   match_q;
  logic [CNT_W-1:0]   count;
  ctrl_t              ctrl_q;
  logic               halted;
  logic               halt_set;
  logic               halt_clr;
  logic               run_en;
  logic               tick;
  logic               hit;
  logic               clr_zero;
  logic               status;
  logic [DATA_W-1:0]  rd_mux;

  // Address decode
  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_valid && bus_write && aligned;
  assign rd_en   = bus_valid && !bus_write;

  assign load_we  = wr_en && (widx == IDX_W'(WI_LOAD));
  assign ctrl_we  = wr_en && (widx == IDX_W'(WI_CTRL));
  assign iclr_we  = wr_en && (widx == IDX_W'(WI_ICLR));
  assign match_we = wr_en && (widx == IDX_W'(WI_MATCH));

  generate
    for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
      assign alias_hit[g] = (widx == IDX_W'(WI_ALIAS0 + g));
    end
  endgenerate

  assign load_view = (widx == IDX_W'(WI_LOAD)) || (widx == IDX_W'(WI_ICLR)) || (|alias_hit);

  assign wdata_cnt = CNT_W'(bus_wdata);

  // Software-visible state
  always_ff @(posedge clk) begin
    if (rst) begin
      load_q  <= '0;
      match_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (load_we)  load_q  <= wdata_cnt;
      if (match_we) match_q <= wdata_cnt;
      if (ctrl_we) begin
        ctrl_q.level  <= bus_wdata[CB_LEVEL];
        ctrl_q.div    <= div_sel_e'({bus_wdata[CB_DIV_HI], bus_wdata[CB_DIV_LO]});
        ctrl_q.reload <= bus_wdata[CB_RELOAD];
        ctrl_q.run    <= bus_wdata[CB_RUN];
      end
    end
  end

  // Freeze on a zero load while auto-reload is on
  assign halt_set = load_we && ctrl_q.reload && (wdata_cnt == '0);
  assign halt_clr = (load_we && (wdata_cnt != '0)) || (ctrl_we && bus_wdata[CB_RUN]);
  assign run_en   = ctrl_q.run && !halted;
  assign clr_zero = iclr_we && (bus_wdata == '0);

  frt_prescale #(
    .MID_LOG2 (MID_LOG2),
    .HI_LOG2  (HI_LOG2)
  ) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clear  (ctrl_we),
    .enable (run_en),
    .sel    (ctrl_q.div),
    .tick   (tick)
  );

  frt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_we   (load_we),
    .load_val  (wdata_cnt),
    .halt_set  (halt_set),
    .halt_clr  (halt_clr),
    .tick      (tick),
    .match_val (match_q),
    .count     (count),
    .halted    (halted),
    .hit       (hit)
  );

  frt_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .level_mode (ctrl_q.level),
    .clr_zero   (clr_zero),
    .status     (status)
  );

  // Registered read path
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (load_view)                         rd_mux = DATA_W'(load_q);
      else if (widx == IDX_W'(WI_COUNT))     rd_mux = DATA_W'(count);
      else if (widx == IDX_W'(WI_CTRL))      rd_mux = DATA_W'(ctrl_word(ctrl_q, status));
      else if (widx == IDX_W'(WI_MATCH))     rd_mux = DATA_W'(match_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  assign irq = status;

endmodule

// File: rtl/frt_match_timer_chk.sv
module frt_match_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             load_we,
  input logic [CNT_W-1:0] wdata_cnt,
  input logic             ctrl_reload,
  input logic             ctrl_run,
  input logic             ctrl_level,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] match_q,
  input logic             halted,
  input logic             hit,
  input logic             clr_zero,
  input logic             irq
);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_we |=> (count == $past(wdata_cnt))); // R3

  AST_ZERO_LOAD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (load_we && ctrl_reload && (wdata_cnt == '0)) |=> (halted && (count == '0))); // R4

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halted && !load_we) |=> $stable(count)); // R4

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    !load_we |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1)))); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_run && !load_we) |=> $stable(count)); // R10

  AST_IRQ_AT_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (count == $past(match_q))); // R6

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (irq && !ctrl_level && !hit) |=> !irq); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (irq && ctrl_level && !clr_zero) |=> irq); // R8

endmodule

bind frt_match_timer frt_match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .load_we     (load_we),
  .wdata_cnt   (wdata_cnt),
  .ctrl_reload (ctrl_q.reload),
  .ctrl_run    (ctrl_q.run),
  .ctrl_level  (ctrl_q.level),
  .count       (count),
  .match_q     (match_q),
  .halted      (halted),
  .hit         (hit),
  .clr_zero    (clr_zero),
  .irq         (irq)
);

// File: tb/tb_frt_match_timer.sv
module tb_frt_match_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr  = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  frt_match_timer dut (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // Vector: {op(1: read-check, 0: write), addr(8), data(32), expected(32)}
  localparam int NV = 17;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h28, 32'h0000_0000, 32'h0},
    {1'b0, 8'h20, 32'h1234_5678, 32'h0},
    {1'b1, 8'h24, 32'h0,         32'h1234_5678}, // R3 load lands in count
    {1'b0, 8'h24, 32'hDEAD_BEEF, 32'h0},
    {1'b1, 8'h24, 32'h0,         32'h1234_5678}, // R9 count not writable
    {1'b1, 8'h20, 32'h0,         32'h1234_5678},
    {1'b1, 8'h2C, 32'h0,         32'h1234_5678},
    {1'b1, 8'h34, 32'h0,         32'h1234_5678},
    {1'b1, 8'h38, 32'h0,         32'h1234_5678},
    {1'b1, 8'h3C, 32'h0,         32'h1234_5678},
    {1'b0, 8'h30, 32'hA5A5_0001, 32'h0},
    {1'b1, 8'h30, 32'h0,         32'hA5A5_0001},
    {1'b0, 8'h28, 32'hFFFF_FF7F, 32'h0},
    {1'b1, 8'h28, 32'h0,         32'h0000_004D}, // R9 control fields
    {1'b0, 8'h28, 32'h0000_0000, 32'h0},
    {1'b1, 8'h10, 32'h0,         32'h0},         // R9 unmapped
    {1'b1, 8'h24, 32'h0,         32'h1234_5678}  // R10 stopped count holds
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int n;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    bus_rd(8'h24, rd); check("R1 count", rd, 32'h0);
    bus_rd(8'h28, rd); check("R1 ctrl",  rd, 32'h0);
    bus_rd(8'h30, rd); check("R1 match", rd, 32'h0);
    bus_rd(8'h20, rd); check("R1 load",  rd, 32'h0);

    // Register map table (R3, R9, R10)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        bus_rd(VEC[i][71:64], rd);
        check($sformatf("R9 vector %0d", i), rd, VEC[i][31:0]);
      end else begin
        bus_wr(VEC[i][71:64], VEC[i][63:32]);
      end
    end

    // R2 R5 R7: divide-by-1, pulse mode, load 10 match 15
    bus_wr(8'h20, 32'd10);
    bus_wr(8'h30, 32'd15);
    bus_wr(8'h28, 32'h80);
    wait_irq(1000, n);
    check("R5 div1 cycles to event", n, 5);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, irq}, 32'h0);

    // R8 latched mode
    bus_wr(8'h28, 32'h0);
    bus_wr(8'h20, 32'd100);
    bus_wr(8'h30, 32'd103);
    bus_wr(8'h28, 32'h81);
    wait_irq(1000, n);
    check("R8 latched cycles to event", n, 3);
    repeat (5) @(negedge clk);
    check("R8 latched holds", {31'b0, irq}, 32'h1);
    bus_rd(8'h28, rd);
    check("R9 status bit in ctrl", rd, 32'h181);
    bus_wr(8'h2C, 32'd5);
    check("R8 nonzero clear ignored", {31'b0, irq}, 32'h1);
    bus_wr(8'h2C, 32'd0);
    check("R8 zero clear", {31'b0, irq}, 32'h0);

    // R5 divide-by-16
    bus_wr(8'h28, 32'h0);
    bus_wr(8'h20, 32'd0);
    bus_wr(8'h30, 32'd2);
    bus_wr(8'h28, 32'h84);
    wait_irq(5000, n);
    check("R5 div16 cycles to event", n, 32);

    // R5 divide-by-256
    bus_wr(8'h28, 32'h0);
    bus_wr(8'h20, 32'd0);
    bus_wr(8'h30, 32'd1);
    bus_wr(8'h28, 32'h88);
    wait_irq(5000, n);
    check("R5 div256 cycles to event", n, 256);

    // R2 wrap through all-ones
    bus_wr(8'h28, 32'h0);
    bus_wr(8'h20, 32'hFFFF_FFFE);
    bus_wr(8'h30, 32'd1);
    bus_wr(8'h28, 32'h80);
    wait_irq(1000, n);
    check("R2 wrap cycles to event", n, 3);

    // R6 sitting on the compare value while stopped fires nothing
    bus_wr(8'h28, 32'h0);
    bus_wr(8'h30, 32'h50);
    bus_wr(8'h20, 32'h50);
    repeat (6) @(negedge clk);
    check("R6 no event on load or while stopped", {31'b0, irq}, 32'h0);

    // R4 zero load under auto-reload freezes
    bus_wr(8'h30, 32'd9);
    bus_wr(8'h20, 32'h0000_AAAA);
    bus_wr(8'h28, 32'hC0);
    bus_wr(8'h20, 32'd0);
    repeat (10) @(negedge clk);
    bus_rd(8'h24, rd);
    check("R4 frozen at zero", rd, 32'h0);
    bus_wr(8'h20, 32'd7);
    wait_irq(1000, n);
    check("R4 nonzero load releases", n, 2);

    // R4 control write with run releases
    bus_wr(8'h20, 32'd0);
    bus_wr(8'h30, 32'd3);
    repeat (4) @(negedge clk);
    bus_wr(8'h28, 32'hC0);
    wait_irq(1000, n);
    check("R4 control run releases", n, 3);

    // R4 reload clear: zero load does not freeze
    bus_wr(8'h28, 32'h80);
    bus_wr(8'h30, 32'd2);
    bus_wr(8'h20, 32'd0);
    wait_irq(1000, n);
    check("R4 zero load without reload runs", n, 2);

    finish_run();
  end

endmodule